// File: doc/BRIEF.md
# Timer Interrupt Line Router with Legacy Takeover

This block sits between a set of timer channels and a bank of interrupt lines. Each channel produces a fire pulse. The block turns that pulse into one of three results: a held level on an interrupt line with a matching status bit, a one-clock pulse on a line, or a message write strobe carrying an address and a data word. The channel's configuration picks the result and the target line. When a channel is switched off, or the block-wide enable is low, its fire pulses are ignored and its status bit is cleared.

A legacy takeover mode lets channel 0 and channel 1 own two fixed lines, line 0 and line 8, in place of their configured routes. In this mode two external legacy sources that normally reach those lines are shut out: a periodic tick source and a clock-alarm level. The block drives an enable output that tells the external tick source to stop while the takeover is active. When the mode is left, line 8 again shows the alarm level that is sampled every clock. Line 0 stays low until the tick source next changes.

All outputs are registered. Inputs sampled at a rising clock edge show on the outputs just after that same edge.

Top module: `tmr_irq_router`

## Requirements
- R1: A synchronous active-high reset clears all interrupt lines, all status bits and all message strobes, and sets `tick_src_en` to 1. A clock-alarm level of 0 is assumed out of reset. Every output reflects the inputs sampled at the rising edge it follows.
- R2: While `legacy_on` is 0, an enabled channel c drives line number `ch_route[c*5 +: 5]`, a 5-bit unsigned line index.
- R3: While `legacy_on` is 1, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Channels 2 and up keep their route fields.
- R4: In level mode (`ch_level[c]`=1), a fire sets `stat[c]` and holds the target line high. Both stay high until a `ch_clr[c]` strobe.
- R5: In edge mode (`ch_level[c]`=0), a fire raises the target line for exactly one clock and leaves `stat[c]` at 0. An edge-mode fire also clears a status bit that is already set.
- R6: While `ch_en[c]` or `glb_en` is 0, fires of channel c have no effect and `stat[c]` is held at 0, which drops its held line.
- R7: When `ch_msg_en[c]` is 1, an enabled fire raises `msg_stb[c]` for one clock. The upper 32 bits of channel c's 64-bit slice of `ch_msg_cfg` appear as `msg_addr`, and the lower 32 bits as `msg_data`, each in channel c's 32-bit slice. No line is driven and `stat[c]` stays 0.
- R8: While `legacy_on` is 0, line 0 takes the new level of `ext_tick_in` each time that input changes. While `legacy_on` is 1, changes of `ext_tick_in` do not reach line 0.
- R9: The `ext_alarm_in` level is sampled every clock and shown on line 8 whenever `legacy_on` is 0. This includes the clock in which the mode is left, so line 8 then shows the level that arrived during the takeover.
- R10: Entering legacy mode lowers the external contributions to lines 0 and 8 and drives `tick_src_en` to 0. Leaving it drives `tick_src_en` to 1 and lowers line 0 until `ext_tick_in` next changes.
- R11: When several drivers target the same line, the line is their logical OR.
- R12: A level-mode fire and a status-clear strobe for the same channel in the same clock leave `stat[c]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Block-wide enable for all channel deliveries |
| legacy_on | input | 1 | Legacy takeover mode |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_fire | input | NUM_CH | Per-channel fire pulse |
| ch_level | input | NUM_CH | 1 = level mode, 0 = edge mode |
| ch_msg_en | input | NUM_CH | Deliver fires as message writes |
| ch_clr | input | NUM_CH | Status clear strobes |
| ch_route | input | NUM_CH*5 | Per-channel target line index |
| ch_msg_cfg | input | NUM_CH*64 | Per-channel message address (upper half) and data (lower half) |
| ext_tick_in | input | 1 | External legacy tick source |
| ext_alarm_in | input | 1 | External clock-alarm level |
| irq_line | output | 32 | Interrupt lines |
| stat | output | NUM_CH | Level-mode status bits |
| tick_src_en | output | 1 | Enable for the external tick source |
| msg_stb | output | NUM_CH | Message write strobes |
| msg_addr | output | NUM_CH*32 | Message address per channel |
| msg_data | output | NUM_CH*32 | Message data per channel |

## Verification
Two functions can collide in one clock. The first is a level-mode fire and a status clear on the same channel. The bench asserts both strobes together and expects the status bit and the line to stay high, then clears alone and expects both low. The second is leaving legacy mode while the alarm input changed during the takeover and the tick input is held high. In that single clock the bench expects line 8 to rise to the new alarm level, line 0 to stay low and the tick-source enable to return. The route sweeps drive every line index from every channel, with and without the takeover, and compute the target line arithmetically.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int LEG_LINE_TMR = 0;
    localparam int LEG_LINE_ALM = 8;
    localparam int MSG_HALF_W   = 32;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_MUTE,
        ACT_LEVEL,
        ACT_EDGE,
        ACT_MSG
    } chan_act_e;

    typedef struct packed {
        logic status;
        logic pulse;
        logic msg;
    } chan_next_t;

    function automatic chan_act_e classify(input logic fire, input logic en_ok,
                                           input logic msg_en, input logic level);
        if (!en_ok)
            return ACT_MUTE;
        else if (msg_en)
            return fire ? ACT_MSG : ACT_MUTE;
        else if (!fire)
            return ACT_IDLE;
        else
            return level ? ACT_LEVEL : ACT_EDGE;
    endfunction

endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
    import tirq_pkg::*;
#(
    parameter int HALF_W = MSG_HALF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                ch_en,
    input  logic                glb_en,
    input  logic                level,
    input  logic                msg_en,
    input  logic                clr,
    input  logic [2*HALF_W-1:0] msg_cfg,
    output logic                status_q,
    output logic                drv_d,
    output logic                msg_stb,
    output logic [HALF_W-1:0]   msg_addr,
    output logic [HALF_W-1:0]   msg_data
);

    chan_act_e  act;
    chan_next_t nxt;

    always_comb act = classify(fire, ch_en & glb_en, msg_en, level);

    always_comb begin
        nxt.status = status_q;
        nxt.pulse  = 1'b0;
        nxt.msg    = 1'b0;
        unique case (act)
            ACT_MUTE:  nxt.status = 1'b0;
            ACT_LEVEL: nxt.status = 1'b1;
            ACT_EDGE: begin
                nxt.status = 1'b0;
                nxt.pulse  = 1'b1;
            end
            ACT_MSG: begin
                nxt.status = 1'b0;
                nxt.msg    = 1'b1;
            end
            default: begin
                if (clr)
                    nxt.status = 1'b0;
            end
        endcase
    end

    // line drive as it will stand after this edge
    always_comb drv_d = nxt.status | nxt.pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
            msg_stb  <= 1'b0;
            msg_addr <= '0;
            msg_data <= '0;
        end else begin
            status_q <= nxt.status;
            msg_stb  <= nxt.msg;
            if (nxt.msg) begin
                msg_addr <= msg_cfg[2*HALF_W-1:HALF_W];
                msg_data <= msg_cfg[HALF_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tirq_legacy.sv
module tirq_legacy (
    input  logic clk,
    input  logic rst,
    input  logic legacy_on,
    input  logic tick_in,
    input  logic alarm_in,
    output logic src_tmr_d,
    output logic src_alm_d,
    output logic tick_src_en
);

    logic leg_q;
    logic tick_prev;
    logic tick_fwd;
    logic tick_fwd_d;

    // tick is forwarded on change only; entering or leaving the mode lowers it
    always_comb begin
        if (legacy_on || leg_q)
            tick_fwd_d = 1'b0;
        else if (tick_in != tick_prev)
            tick_fwd_d = tick_in;
        else
            tick_fwd_d = tick_fwd;
    end

    always_comb src_tmr_d = tick_fwd_d;
    // alarm level is sampled every clock and shown whenever the mode is off
    always_comb src_alm_d = alarm_in & ~legacy_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            leg_q       <= 1'b0;
            tick_prev   <= 1'b0;
            tick_fwd    <= 1'b0;
            tick_src_en <= 1'b1;
        end else begin
            leg_q       <= legacy_on;
            tick_prev   <= tick_in;
            tick_fwd    <= tick_fwd_d;
            tick_src_en <= ~legacy_on;
        end
    end

endmodule

// File: rtl/tirq_line_merge.sv
module tirq_line_merge
    import tirq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 32,
    parameter int ROUTE_W   = 5,
    parameter int TMR_LINE  = LEG_LINE_TMR,
    parameter int ALM_LINE  = LEG_LINE_ALM
) (
    input  logic [NUM_CH-1:0]         drv_d,
    input  logic [NUM_CH*ROUTE_W-1:0] route,
    input  logic                      legacy_on,
    input  logic                      src_tmr_d,
    input  logic                      src_alm_d,
    output logic [NUM_LINES-1:0]      line_d
);

    logic [NUM_CH-1:0][ROUTE_W-1:0] tgt;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_tgt
        if (c == 0) begin : g_c0
            assign tgt[c] = legacy_on ? ROUTE_W'(TMR_LINE) : route[c*ROUTE_W +: ROUTE_W];
        end else if (c == 1) begin : g_c1
            assign tgt[c] = legacy_on ? ROUTE_W'(ALM_LINE) : route[c*ROUTE_W +: ROUTE_W];
        end else begin : g_cn
            assign tgt[c] = route[c*ROUTE_W +: ROUTE_W];
        end
    end

    always_comb begin
        line_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (drv_d[c])
                line_d[tgt[c]] = 1'b1;
        end
        line_d[TMR_LINE] = line_d[TMR_LINE] | src_tmr_d;
        line_d[ALM_LINE] = line_d[ALM_LINE] | src_alm_d;
    end

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tirq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 32,
    parameter int TMR_LINE  = LEG_LINE_TMR,
    parameter int ALM_LINE  = LEG_LINE_ALM,
    localparam int ROUTE_W  = $clog2(NUM_LINES),
    localparam int HALF_W   = MSG_HALF_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      glb_en,
    input  logic                      legacy_on,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_fire,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH-1:0]         ch_clr,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH*2*HALF_W-1:0] ch_msg_cfg,
    input  logic                      ext_tick_in,
    input  logic                      ext_alarm_in,
    output logic [NUM_LINES-1:0]      irq_line,
    output logic [NUM_CH-1:0]         stat,
    output logic                      tick_src_en,
    output logic [NUM_CH-1:0]         msg_stb,
    output logic [NUM_CH*HALF_W-1:0]  msg_addr,
    output logic [NUM_CH*HALF_W-1:0]  msg_data
);

    logic [NUM_CH-1:0]    drv_d;
    logic [NUM_LINES-1:0] line_d;
    logic                 src_tmr_d;
    logic                 src_alm_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tirq_chan #(.HALF_W(HALF_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .fire     (ch_fire[c]),
            .ch_en    (ch_en[c]),
            .glb_en   (glb_en),
            .level    (ch_level[c]),
            .msg_en   (ch_msg_en[c]),
            .clr      (ch_clr[c]),
            .msg_cfg  (ch_msg_cfg[c*2*HALF_W +: 2*HALF_W]),
            .status_q (stat[c]),
            .drv_d    (drv_d[c]),
            .msg_stb  (msg_stb[c]),
            .msg_addr (msg_addr[c*HALF_W +: HALF_W]),
            .msg_data (msg_data[c*HALF_W +: HALF_W])
        );
    end

    tirq_legacy u_legacy (
        .clk         (clk),
        .rst         (rst),
        .legacy_on   (legacy_on),
        .tick_in     (ext_tick_in),
        .alarm_in    (ext_alarm_in),
        .src_tmr_d   (src_tmr_d),
        .src_alm_d   (src_alm_d),
        .tick_src_en (tick_src_en)
    );

    tirq_line_merge #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W),
        .TMR_LINE  (TMR_LINE),
        .ALM_LINE  (ALM_LINE)
    ) u_merge (
        .drv_d     (drv_d),
        .route     (ch_route),
        .legacy_on (legacy_on),
        .src_tmr_d (src_tmr_d),
        .src_alm_d (src_alm_d),
        .line_d    (line_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_line <= '0;
        else
            irq_line <= line_d;
    end

endmodule

// File: rtl/tirq_router_chk.sv
module tirq_router_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              glb_en,
    input logic              legacy_on,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_fire,
    input logic [NUM_CH-1:0] ch_msg_en,
    input logic [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0] msg_stb,
    input logic              tick_src_en
);

    // R6
    glb_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> stat == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R6
        chan_off_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |=> !stat[i]);
    end

    // R10
    leg_enter_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_on |=> !tick_src_en);

    // R10
    leg_leave_chk: assert property (@(posedge clk) disable iff (rst)
        !legacy_on |=> tick_src_en);

    // R7
    msg_fire_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> msg_stb == $past(ch_fire & ch_en & ch_msg_en & {NUM_CH{glb_en}}));

    // R7
    msg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_stb & stat) == '0);

endmodule

bind tmr_irq_router tirq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .glb_en      (glb_en),
    .legacy_on   (legacy_on),
    .ch_en       (ch_en),
    .ch_fire     (ch_fire),
    .ch_msg_en   (ch_msg_en),
    .stat        (stat),
    .msg_stb     (msg_stb),
    .tick_src_en (tick_src_en)
);

// File: tb/tmr_irq_router_test.sv
module tmr_irq_router_test;

    localparam int NCH = 4;
    localparam int NL  = 32;
    localparam int RW  = 5;
    localparam int HW  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              glb_en = 1'b0;
    logic              legacy_on = 1'b0;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH-1:0]    ch_fire = '0;
    logic [NCH-1:0]    ch_level = '0;
    logic [NCH-1:0]    ch_msg_en = '0;
    logic [NCH-1:0]    ch_clr = '0;
    logic [NCH*RW-1:0] ch_route = '0;
    logic [NCH*2*HW-1:0] ch_msg_cfg = '0;
    logic              ext_tick_in = 1'b0;
    logic              ext_alarm_in = 1'b0;
    logic [NL-1:0]     irq_line;
    logic [NCH-1:0]    stat;
    logic              tick_src_en;
    logic [NCH-1:0]    msg_stb;
    logic [NCH*HW-1:0] msg_addr;
    logic [NCH*HW-1:0] msg_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_irq_router uut (
        .clk (clk), .rst (rst), .glb_en (glb_en), .legacy_on (legacy_on),
        .ch_en (ch_en), .ch_fire (ch_fire), .ch_level (ch_level),
        .ch_msg_en (ch_msg_en), .ch_clr (ch_clr), .ch_route (ch_route),
        .ch_msg_cfg (ch_msg_cfg), .ext_tick_in (ext_tick_in),
        .ext_alarm_in (ext_alarm_in), .irq_line (irq_line), .stat (stat),
        .tick_src_en (tick_src_en), .msg_stb (msg_stb),
        .msg_addr (msg_addr), .msg_data (msg_data)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fire(input logic [NCH-1:0] m);
        ch_fire = m;
        step();
        ch_fire = '0;
    endtask

    function automatic int target(input int ch, input int r, input bit leg);
        if (leg && ch == 0) return 0;
        if (leg && ch == 1) return 8;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R1: reset state while held
        check("R1", "irq_line in reset", 64'(irq_line), 0);
        check("R1", "stat in reset", 64'(stat), 0);
        check("R1", "msg_stb in reset", 64'(msg_stb), 0);
        check("R1", "tick_src_en in reset", 64'(tick_src_en), 1);
        rst = 1'b0;
        step();
        check("R1", "irq_line after reset", 64'(irq_line), 0);
        check("R1", "tick_src_en after reset", 64'(tick_src_en), 1);

        glb_en = 1'b1;
        ch_en  = '1;

        // R2, R3, R5: edge-mode route sweep with and without takeover
        for (int leg = 0; leg < 2; leg++) begin
            legacy_on = leg[0];
            step();
            for (int ch = 0; ch < NCH; ch++) begin
                for (int r = 0; r < NL; r++) begin
                    ch_route[ch*RW +: RW] = RW'(r);
                    fire(NCH'(1) << ch);
                    check(leg ? "R3" : "R2", "edge line",
                          64'(irq_line), 64'(NL'(1) << target(ch, r, leg[0])));
                    check("R5", "edge stat", 64'(stat), 0);
                    step();
                    check("R5", "pulse one clock", 64'(irq_line), 0);
                end
            end
        end
        legacy_on = 1'b0;
        step();

        // R4: level mode hold and clear
        ch_route = '0;
        ch_route[2*RW +: RW] = 5'd5;
        ch_level[2] = 1'b1;
        fire(4'b0100);
        check("R4", "level line", 64'(irq_line), 64'(32'h20));
        check("R4", "level stat", 64'(stat), 64'(4'b0100));
        step(); step(); step();
        check("R4", "level held", 64'(irq_line), 64'(32'h20));
        ch_clr[2] = 1'b1; step(); ch_clr = '0;
        check("R4", "cleared stat", 64'(stat), 0);
        check("R4", "cleared line", 64'(irq_line), 0);

        // R12: fire and clear in one clock
        ch_clr[2] = 1'b1;
        fire(4'b0100);
        ch_clr = '0;
        check("R12", "fire beats clear stat", 64'(stat), 64'(4'b0100));
        check("R12", "fire beats clear line", 64'(irq_line), 64'(32'h20));
        ch_clr[2] = 1'b1; step(); ch_clr = '0;
        check("R12", "later clear", 64'(stat), 0);

        // R5: edge fire clears an existing status
        fire(4'b0100);
        ch_level[2] = 1'b0;
        fire(4'b0100);
        check("R5", "edge fire clears stat", 64'(stat), 0);
        check("R5", "edge fire pulse", 64'(irq_line), 64'(32'h20));
        step();
        check("R5", "pulse ends", 64'(irq_line), 0);

        // R6: channel disable and block disable
        ch_level[2] = 1'b1;
        ch_en[2] = 1'b0;
        fire(4'b0100);
        check("R6", "disabled fire stat", 64'(stat), 0);
        check("R6", "disabled fire line", 64'(irq_line), 0);
        ch_en[2] = 1'b1;
        fire(4'b0100);
        check("R6", "re-enabled fire", 64'(stat), 64'(4'b0100));
        ch_en[2] = 1'b0; step(); ch_en[2] = 1'b1;
        check("R6", "disable clears stat", 64'(stat), 0);
        check("R6", "disable drops line", 64'(irq_line), 0);
        fire(4'b0100);
        glb_en = 1'b0; step();
        check("R6", "global off clears stat", 64'(stat), 0);
        fire(4'b0100);
        check("R6", "global off fire line", 64'(irq_line), 0);
        glb_en = 1'b1;
        ch_level = '0;
        step();

        // R7: message delivery
        for (int c = 0; c < NCH; c++)
            ch_msg_cfg[c*2*HW +: 2*HW] = {32'hFEED_0040 + 32'(c), 32'h0000_00C3 + 32'(c)};
        ch_msg_en[1] = 1'b1;
        ch_level[1]  = 1'b1;
        fire(4'b0010);
        check("R7", "msg strobe", 64'(msg_stb), 64'(4'b0010));
        check("R7", "msg addr", 64'(msg_addr[1*HW +: HW]), 64'(32'hFEED_0041));
        check("R7", "msg data", 64'(msg_data[1*HW +: HW]), 64'(32'h0000_00C4));
        check("R7", "msg no line", 64'(irq_line), 0);
        check("R7", "msg no stat", 64'(stat), 0);
        step();
        check("R7", "msg strobe one clock", 64'(msg_stb), 0);
        ch_msg_en = '0;
        ch_level  = '0;

        // R11: two level channels share a line
        ch_route[0*RW +: RW] = 5'd7;
        ch_route[3*RW +: RW] = 5'd7;
        ch_level = 4'b1001;
        fire(4'b1001);
        check("R11", "shared line", 64'(irq_line), 64'(32'h80));
        check("R11", "both stat", 64'(stat), 64'(4'b1001));
        ch_clr = 4'b0001; step(); ch_clr = '0;
        check("R11", "one still drives", 64'(irq_line), 64'(32'h80));
        ch_clr = 4'b1000; step(); ch_clr = '0;
        check("R11", "none drives", 64'(irq_line), 0);
        ch_level = '0;

        // R8: tick forwarding
        ext_tick_in = 1'b1; step();
        check("R8", "tick rise forwarded", 64'(irq_line), 64'(32'h1));
        step();
        check("R8", "tick held", 64'(irq_line), 64'(32'h1));
        ext_tick_in = 1'b0; step();
        check("R8", "tick fall forwarded", 64'(irq_line), 0);
        legacy_on = 1'b1; step();
        check("R10", "enter disables tick source", 64'(tick_src_en), 0);
        ext_tick_in = 1'b1; step();
        check("R8", "tick gated in takeover", 64'(irq_line), 0);

        // R9/R10: leave with alarm changed during takeover and tick high
        legacy_on = 1'b0; ext_alarm_in = 1'b0; step();
        legacy_on = 1'b1; step();
        ext_alarm_in = 1'b1; step();
        check("R10", "alarm gated in takeover", 64'(irq_line), 0);
        legacy_on = 1'b0; step();
        check("R9", "alarm restored on leave", 64'(irq_line), 64'(32'h100));
        check("R10", "leave lowers line 0", 64'(irq_line[0]), 0);
        check("R10", "leave enables tick source", 64'(tick_src_en), 1);
        ext_tick_in = 1'b0; step();
        ext_tick_in = 1'b1; step();
        check("R8", "tick forwarded after leave", 64'(irq_line), 64'(32'h101));

        // R10: entering lowers both legacy lines
        legacy_on = 1'b1; step();
        check("R10", "enter lowers 0 and 8", 64'(irq_line), 0);
        legacy_on = 1'b0; ext_alarm_in = 1'b0; ext_tick_in = 1'b0; step();
        check("R9", "alarm low", 64'(irq_line), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule